// File: doc/BRIEF.md
# DRAM Refresh Pacer with Burst Deferral

This block decides when a DRAM controller should run a refresh cycle. A divide-by-16 prescaler feeds a reloadable interval counter, so one refresh falls due every 16·(N+1) system clocks. N is a 6-bit rate value taken from a configuration word. For example, a 25 MHz clock with N = 24 gives one refresh every 400 clocks (16 µs), so 256 rows are covered in 4.096 ms. The refresh sequencing itself (row and column strobes) belongs to the controller downstream and is not part of this block.

A refresh that falls due is never allowed to cut into a burst. Each due refresh is added to a debt counter. The block offers refreshes downstream through a valid/ready pair: `refresh_req` (valid) and `refresh_ack` (ready). A refresh is retired only on a cycle where both are high. Back-pressure is simple. While the controller holds `refresh_ack` low, the request stays up and the debt is kept. While `burst_active` is high, the request is withdrawn, and an acknowledge on those cycles has no effect. When the burst ends, the owed refreshes are offered back to back until the debt reaches zero, so the full set of rows is still covered in its period. The debt saturates at 8, and losing a refresh at that limit sets a sticky overflow flag.

Top module: `dram_refresh_pacer`

## Requirements
- R1: While reset is asserted and right after it, `refresh_req` and `debt_overflow` are low.
- R2: The rate value N is `cfg_word[13:8]`, with bit 13 the most significant. All other bits of `cfg_word` have no effect on timing.
- R3: N is sampled on the first clock after reset is released. The first refresh falls due at the 16·(N+1)-th rising edge after release, and `refresh_req` is high right after that edge when no burst is running.
- R4: While N is unchanged, further refreshes fall due every 16·(N+1) clocks. For N = 24 this is 400 clocks.
- R5: A new N is used only from the next reload, which happens when a refresh falls due. The interval already running finishes at the old rate.
- R6: A refresh is retired only on an edge where `refresh_req` and `refresh_ack` are both high. While debt remains and `refresh_ack` is low, the request holds. An acknowledge with no debt has no effect.
- R7: While `burst_active` is high, `refresh_req` is low. Refreshes that fall due are still counted, and an acknowledge on those cycles retires nothing.
- R8: When a burst ends with debt k > 0, `refresh_req` is high at once. It stays high across k consecutive acknowledged edges and drops after the k-th.
- R9: The debt saturates at 8. A refresh that falls due at 8 with no handshake on the same edge sets `debt_overflow`. If a handshake coincides with it, the debt stays at 8 and no overflow is flagged.
- R10: `debt_overflow` stays set until reset, and reset clears the debt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 16 | Configuration word; bits 13:8 hold the rate value N |
| burst_active | input | 1 | High while a burst owns the memory |
| refresh_ack | input | 1 | Ready: the controller accepts a refresh this cycle |
| refresh_req | output | 1 | Valid: at least one refresh owed and no burst running |
| debt_overflow | output | 1 | Sticky: a due refresh was lost at the debt limit |

## Verification
The hardest case to reach from the ports is a refresh falling due on the same edge that retires one while the debt sits at its limit of 8. The stimulus uses N = 0 so refreshes arrive every 16 clocks. It holds a burst for eight intervals, then releases the burst and raises the acknowledge exactly one clock before the ninth refresh falls due. The overflow flag must stay low, and exactly eight more acknowledges must drain the request. The same setup without the acknowledge checks that the flag is set, that it is sticky, and that the debt is still capped at 8.

// File: rtl/refpace_pkg.sv
package refpace_pkg;
  localparam int CFG_W      = 16;
  localparam int FREQ_LSB   = 8;
  localparam int FREQ_W     = 6;
  localparam int PRE_W      = 4;
  localparam int DEBT_LIMIT = 8;
  localparam int DEBT_W     = $clog2(DEBT_LIMIT + 1);
endpackage

// File: rtl/refpace_prescale.sv
module refpace_prescale #(
  parameter int DIV_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic pre_tick
);
  logic [DIV_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + DIV_W'(1);
  end

  assign pre_tick = &pre_q;

  a_r3_pre_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |=> (pre_q == '0));
endmodule

// File: rtl/refpace_interval.sv
module refpace_interval #(
  parameter int N_W = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pre_tick,
  input  logic [N_W-1:0] n_in,
  output logic           due_tick
);
  logic           primed_q;
  logic [N_W-1:0] iv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      iv_q     <= '0;
    end else if (!primed_q) begin
      primed_q <= 1'b1;
      iv_q     <= n_in;
    end else if (pre_tick) begin
      if (iv_q == '0) iv_q <= n_in;
      else            iv_q <= iv_q - N_W'(1);
    end
  end

  assign due_tick = primed_q && pre_tick && (iv_q == '0);

  // R5: the reload takes the rate present on the due edge
  a_r5_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    due_tick |=> (iv_q == $past(n_in)));
  // R4: between reloads the counter only steps down on prescaler ticks
  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && pre_tick && iv_q != '0) |=> (iv_q == $past(iv_q) - N_W'(1)));
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && !pre_tick) |=> $stable(iv_q));
endmodule

// File: rtl/refpace_debt.sv
module refpace_debt #(
  parameter int LIMIT = 8,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic due_tick,
  input  logic take,
  output logic debt_nz,
  output logic overflow
);
  logic [CW-1:0] debt_q;
  logic          ovf_q;
  logic          at_cap;

  assign at_cap = (debt_q == CW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      debt_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      unique case ({due_tick, take})
        2'b10: begin
          if (at_cap) ovf_q  <= 1'b1;
          else        debt_q <= debt_q + CW'(1);
        end
        2'b01:   debt_q <= debt_q - CW'(1);
        default: debt_q <= debt_q;
      endcase
    end
  end

  assign debt_nz  = (debt_q != '0);
  assign overflow = ovf_q;

  a_r9_cap: assert property (@(posedge clk) disable iff (!rst_n)
    debt_q <= CW'(LIMIT));
  a_r9_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (due_tick && !take && at_cap) |=> ovf_q);
  a_r9_coincide_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (due_tick && take) |=> $stable(debt_q));
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  a_r6_retire_one: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !due_tick) |=> (debt_q == $past(debt_q) - CW'(1)));
  a_r6_take_needs_debt: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (debt_q != '0));
endmodule

// File: rtl/dram_refresh_pacer.sv
module dram_refresh_pacer
  import refpace_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             burst_active,
  input  logic             refresh_ack,
  output logic             refresh_req,
  output logic             debt_overflow
);
  logic              pre_tick;
  logic              due_tick;
  logic              debt_nz;
  logic              take;
  logic [FREQ_W-1:0] n_field;
  logic              cfg_spare_unused;

  assign n_field          = cfg_word[FREQ_LSB +: FREQ_W];
  assign cfg_spare_unused = ^{cfg_word[CFG_W-1:FREQ_LSB+FREQ_W], cfg_word[FREQ_LSB-1:0]};

  refpace_prescale #(.DIV_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .pre_tick (pre_tick)
  );

  refpace_interval #(.N_W(FREQ_W)) u_iv (
    .clk      (clk),
    .rst_n    (rst_n),
    .pre_tick (pre_tick),
    .n_in     (n_field),
    .due_tick (due_tick)
  );

  assign refresh_req = debt_nz && !burst_active;
  assign take        = refresh_req && refresh_ack;

  refpace_debt #(.LIMIT(DEBT_LIMIT), .CW(DEBT_W)) u_debt (
    .clk      (clk),
    .rst_n    (rst_n),
    .due_tick (due_tick),
    .take     (take),
    .debt_nz  (debt_nz),
    .overflow (debt_overflow)
  );

  // R6: an offered refresh that is not accepted stays offered unless a burst takes over
  a_r6_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !refresh_ack) |=> (refresh_req || burst_active));
  // R7: nothing is retired while a burst runs
  a_r7_burst_no_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && !due_tick) |=> ($past(debt_nz) == debt_nz || debt_nz));
endmodule

// File: tb/dram_refresh_pacer_tb.sv
module dram_refresh_pacer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_word = '0;
  logic        burst_active = 1'b0;
  logic        refresh_ack = 1'b0;
  logic        refresh_req;
  logic        debt_overflow;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  dram_refresh_pacer u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_word      (cfg_word),
    .burst_active  (burst_active),
    .refresh_ack   (refresh_ack),
    .refresh_req   (refresh_req),
    .debt_overflow (debt_overflow)
  );

  function automatic logic [15:0] mk_cfg(input int n, input logic [9:0] junk);
    return {junk[9:8], 6'(n), junk[7:0]};
  endfunction

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic do_reset(input logic [15:0] cfg, input logic burst);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_word = cfg;
    burst_active = burst;
    refresh_ack = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // advance to just after rising edge number c since reset release
  task automatic at_edge(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // one acknowledged edge
  task automatic ack_once();
    refresh_ack = 1'b1;
    @(negedge clk);
    refresh_ack = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "req in reset", refresh_req, 0);
    check("R1", "ovf in reset", debt_overflow, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "req after release", refresh_req, 0);
  endtask

  task automatic t_cadence();
    do_reset(mk_cfg(2, 10'h3FF), 1'b0);
    at_edge(47);
    check("R3", "req before first due", refresh_req, 0);
    at_edge(48);
    check("R3", "req at first due (R2 field)", refresh_req, 1);
    at_edge(50);
    check("R6", "req held without ack", refresh_req, 1);
    ack_once();
    check("R6", "req after one handshake", refresh_req, 0);
    ack_once();
    check("R6", "ack with no debt ignored", refresh_req, 0);
    at_edge(95);
    check("R4", "req before second due", refresh_req, 0);
    at_edge(96);
    check("R4", "req at second due", refresh_req, 1);
    ack_once();
    check("R6", "second retire", refresh_req, 0);
  endtask

  task automatic t_slow_rate();
    do_reset(mk_cfg(24, 10'h000), 1'b0);
    at_edge(399);
    check("R4", "N=24 before 400", refresh_req, 0);
    at_edge(400);
    check("R4", "N=24 at 400", refresh_req, 1);
  endtask

  task automatic t_rate_change();
    do_reset(mk_cfg(2, 10'h155), 1'b0);
    at_edge(10);
    cfg_word = mk_cfg(5, 10'h2AA);
    at_edge(47);
    check("R5", "old interval before due", refresh_req, 0);
    at_edge(48);
    check("R5", "old interval kept", refresh_req, 1);
    ack_once();
    at_edge(143);
    check("R5", "new interval before due", refresh_req, 0);
    at_edge(144);
    check("R5", "new interval at 96", refresh_req, 1);
  endtask

  task automatic t_burst_defer();
    do_reset(mk_cfg(2, 10'h0), 1'b1);
    at_edge(145);
    check("R7", "req low in burst", refresh_req, 0);
    ack_once();
    check("R7", "req still low after ack in burst", refresh_req, 0);
    burst_active = 1'b0;
    #1;
    check("R8", "req at burst end", refresh_req, 1);
    @(negedge clk);
    refresh_ack = 1'b1;
    @(negedge clk);
    check("R8", "after 1st of 3", refresh_req, 1);
    @(negedge clk);
    check("R8", "after 2nd of 3", refresh_req, 1);
    @(negedge clk);
    refresh_ack = 1'b0;
    check("R8", "after 3rd of 3", refresh_req, 0);
  endtask

  task automatic t_saturate();
    do_reset(mk_cfg(0, 10'h0), 1'b1);
    at_edge(128);
    check("R9", "no ovf at 8 owed", debt_overflow, 0);
    at_edge(144);
    check("R9", "ovf on 9th due", debt_overflow, 1);
    burst_active = 1'b0;
    for (int i = 0; i < 7; i++) ack_once();
    check("R9", "req after 7 of 8", refresh_req, 1);
    ack_once();
    check("R9", "debt capped at 8", refresh_req, 0);
    check("R10", "ovf sticky", debt_overflow, 1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10", "reset clears ovf", debt_overflow, 0);
    check("R10", "reset clears debt", refresh_req, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_coincide();
    do_reset(mk_cfg(0, 10'h0), 1'b1);
    at_edge(143);
    burst_active = 1'b0;
    ack_once();
    check("R9", "no ovf on coincident handshake", debt_overflow, 0);
    for (int i = 0; i < 7; i++) ack_once();
    check("R9", "req after 7 more", refresh_req, 1);
    ack_once();
    check("R9", "drained after 8 more", refresh_req, 0);
  endtask

  initial begin
    t_reset();
    t_cadence();
    t_slow_rate();
    t_rate_change();
    t_burst_defer();
    t_saturate();
    t_coincide();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule